// File: doc/BRIEF.md
# Configuration Completion Retry-Status Filter

This block sits on the completion return path of a root port, between the core that receives configuration completions and two consumers: a user receive interface that sees the full completion (status and data), and a command/status register interface that sees an acknowledge strobe, a retry flag and the read data. Every completion presented at the input is routed to exactly one of the two consumers. It appears there one clock later, through a single register stage.

The block applies the software-visibility rule for the retry status. A completion may carry status code 2, which means the target asked for the configuration request to be retried. If the root-control visibility enable is set and that completion answers a read of dword offset 0, the block does not pass the retry upward. It turns the completion into a successful one whose data holds the vendor-ID placeholder 0x0001 in the low half, with every higher bit set. On the command/status interface the retry flag then stays low. A retry completion for any other request keeps its status and its data. So does any retry completion while the enable is clear. On the command/status interface such a completion raises the retry flag together with the acknowledge. The block does not reissue requests.

Top module: `cpl_crs_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rx_valid, cs_ack and cs_crs are low.
- R2: A completion whose status is not 2 (0 = success, 1 = unsupported request, 4 = completer abort) appears one cycle after it is presented, with its status and data unchanged. This holds whatever the visibility enable and the offset are.
- R3: When crs_vis_en is 0, a completion with status 2 is forwarded with status 2 and its data unchanged, whatever the offset or direction.
- R4: When crs_vis_en is 1, a read (cpl_is_write = 0) of dword offset 0 that completes with status 2 is forwarded with status 0 and data 0xFFFF0001.
- R5: When crs_vis_en is 1, a status-2 completion for a write, or for a read of any nonzero offset, is forwarded with status 2 and its data unchanged.
- R6: On the command/status interface (cpl_to_cs = 1), cs_crs is high exactly in the cycle of a cs_ack whose forwarded status is 2. It is never high without cs_ack.
- R7: On the command/status interface, a substituted completion (the R4 case) gives cs_ack with cs_crs low and cs_data = 0xFFFF0001.
- R8: Each completion gives exactly one single-cycle strobe on the interface it is routed to: rx_valid when cpl_to_cs = 0, cs_ack when cpl_to_cs = 1. The other strobe stays low. No strobe appears in a cycle that follows no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid | input | 1 | A completion is presented this cycle |
| cpl_to_cs | input | 1 | Route: 1 = command/status interface, 0 = user receive interface |
| cpl_status | input | 3 | Completion status code (2 = retry) |
| cpl_offset | input | OFF_W (10) | Dword offset of the originating request |
| cpl_is_write | input | 1 | Originating request was a write |
| cpl_data | input | DATA_W (32) | Completion data |
| crs_vis_en | input | 1 | Retry software-visibility enable from root control |
| rx_valid | output | 1 | Completion strobe on the receive interface |
| rx_status | output | 3 | Forwarded status on the receive interface |
| rx_data | output | DATA_W (32) | Forwarded data on the receive interface |
| cs_ack | output | 1 | Acknowledge pulse on the command/status interface |
| cs_crs | output | 1 | Retry indication, valid with cs_ack |
| cs_data | output | DATA_W (32) | Read data on the command/status interface |

## Verification
A wrong substitution decision shows on the port in the very next cycle. Either a retry status leaks past an enabled visibility bit, or the placeholder overwrites real data of a write or a nonzero-offset read. The scoreboard compares status and data on each forwarded completion, so either error is caught on the first affected transfer. A routing or strobe error shows as a missing, doubled or wrong-side strobe one cycle after the input. Because idle cycles are scored too, a stray strobe is caught in the cycle it appears.

// File: rtl/cplcrs_pkg.sv
package cplcrs_pkg;
   localparam int unsigned STATUS_W = 3;
   localparam int unsigned VID_W    = 16;
   localparam int unsigned NUM_DEST = 2;

   localparam logic [STATUS_W-1:0] ST_SC  = 3'd0;
   localparam logic [STATUS_W-1:0] ST_UR  = 3'd1;
   localparam logic [STATUS_W-1:0] ST_CRS = 3'd2;
   localparam logic [STATUS_W-1:0] ST_CA  = 3'd4;

   localparam logic [VID_W-1:0] VID_PLACEHOLDER = 16'h0001;
endpackage

// File: rtl/cplcrs_classify.sv
module cplcrs_classify
   import cplcrs_pkg::*;
#(
   parameter int unsigned OFF_W  = 10,
   parameter int unsigned DATA_W = 32
) (
   input  logic [STATUS_W-1:0] status_i,
   input  logic [OFF_W-1:0]    offset_i,
   input  logic                is_write_i,
   input  logic [DATA_W-1:0]   data_i,
   input  logic                vis_en_i,
   output logic [STATUS_W-1:0] status_o,
   output logic [DATA_W-1:0]   data_o
);
   localparam int unsigned FILL_W = DATA_W - VID_W;

   logic [DATA_W-1:0] pattern;
   logic              swap;

   generate
      if (DATA_W < VID_W) begin : g_bad_width
         $error("cplcrs_classify: DATA_W must hold the vendor-ID field");
      end else if (FILL_W == 0) begin : g_vid_only
         assign pattern = VID_PLACEHOLDER;
      end else begin : g_vid_fill
         assign pattern = {{FILL_W{1'b1}}, VID_PLACEHOLDER};
      end
      if (OFF_W < 1) begin : g_bad_off
         $error("cplcrs_classify: OFF_W must be at least 1");
      end
   endgenerate

   always_comb begin
      swap = (status_i == ST_CRS) && vis_en_i && !is_write_i && (offset_i == '0);
      if (swap) begin
         status_o = ST_SC;
         data_o   = pattern;
      end else begin
         status_o = status_i;
         data_o   = data_i;
      end
   end
endmodule

// File: rtl/cplcrs_port_reg.sv
module cplcrs_port_reg
   import cplcrs_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [STATUS_W-1:0] status_i,
   input  logic [DATA_W-1:0]   data_i,
   output logic                vld_o,
   output logic [STATUS_W-1:0] status_o,
   output logic [DATA_W-1:0]   data_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o    <= 1'b0;
         status_o <= ST_SC;
         data_o   <= '0;
      end else begin
         vld_o <= load_i;
         if (load_i) begin
            status_o <= status_i;
            data_o   <= data_i;
         end
      end
   end
endmodule

// File: rtl/cpl_crs_filter.sv
module cpl_crs_filter
   import cplcrs_pkg::*;
#(
   parameter int unsigned OFF_W  = 10,
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpl_valid,
   input  logic                cpl_to_cs,
   input  logic [2:0]          cpl_status,
   input  logic [OFF_W-1:0]    cpl_offset,
   input  logic                cpl_is_write,
   input  logic [DATA_W-1:0]   cpl_data,
   input  logic                crs_vis_en,
   output logic                rx_valid,
   output logic [2:0]          rx_status,
   output logic [DATA_W-1:0]   rx_data,
   output logic                cs_ack,
   output logic                cs_crs,
   output logic [DATA_W-1:0]   cs_data
);
   localparam int unsigned DEST_RX = 0;
   localparam int unsigned DEST_CS = 1;

   logic [STATUS_W-1:0] fwd_status;
   logic [DATA_W-1:0]   fwd_data;

   logic                stg_vld    [NUM_DEST];
   logic [STATUS_W-1:0] stg_status [NUM_DEST];
   logic [DATA_W-1:0]   stg_data   [NUM_DEST];

   generate
      if (STATUS_W != 3) begin : g_bad_status
         $error("cpl_crs_filter: status field must be 3 bits");
      end
   endgenerate

   cplcrs_classify #(
      .OFF_W  (OFF_W),
      .DATA_W (DATA_W)
   ) i_classify (
      .status_i   (cpl_status),
      .offset_i   (cpl_offset),
      .is_write_i (cpl_is_write),
      .data_i     (cpl_data),
      .vis_en_i   (crs_vis_en),
      .status_o   (fwd_status),
      .data_o     (fwd_data)
   );

   generate
      for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
         logic sel;
         assign sel = cpl_valid && ((g == DEST_CS) ? cpl_to_cs : !cpl_to_cs);
         cplcrs_port_reg #(
            .DATA_W (DATA_W)
         ) i_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (sel),
            .status_i (fwd_status),
            .data_i   (fwd_data),
            .vld_o    (stg_vld[g]),
            .status_o (stg_status[g]),
            .data_o   (stg_data[g])
         );
      end
   endgenerate

   assign rx_valid  = stg_vld[DEST_RX];
   assign rx_status = stg_status[DEST_RX];
   assign rx_data   = stg_data[DEST_RX];
   assign cs_ack    = stg_vld[DEST_CS];
   assign cs_crs    = stg_vld[DEST_CS] && (stg_status[DEST_CS] == ST_CRS);
   assign cs_data   = stg_data[DEST_CS];

   AST_CRS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cs_crs |-> cs_ack);  // R6
   AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && cs_ack));  // R8
   AST_STROBE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_to_cs |=> rx_valid && !cs_ack);  // R8
   AST_PASS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_to_cs && cpl_status != ST_CRS |=>
         rx_status == $past(cpl_status) && rx_data == $past(cpl_data));  // R2
   AST_NOVIS_KEEPS_CRS: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_to_cs && cpl_status == ST_CRS && !crs_vis_en |=>
         rx_status == ST_CRS && rx_data == $past(cpl_data));  // R3
   AST_VIS_HIDES_RX: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_to_cs && crs_vis_en && !cpl_is_write && cpl_offset == '0 |=>
         rx_status != ST_CRS);  // R4
   AST_VIS_HIDES_CS: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && cpl_to_cs && crs_vis_en && !cpl_is_write && cpl_offset == '0 |=>
         cs_ack && !cs_crs);  // R7
endmodule

// File: tb/test_cpl_crs_filter.sv
module test_cpl_crs_filter;
   localparam int OFF_W  = 10;
   localparam int DATA_W = 32;

   typedef struct {
      int          kind;   // 0 idle, 1 rx, 2 cs
      logic [2:0]  status;
      logic [31:0] data;
      logic        crs;
      string       tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpl_valid = 1'b0;
   logic              cpl_to_cs = 1'b0;
   logic [2:0]        cpl_status = 3'd0;
   logic [OFF_W-1:0]  cpl_offset = '0;
   logic              cpl_is_write = 1'b0;
   logic [DATA_W-1:0] cpl_data = '0;
   logic              crs_vis_en = 1'b0;
   logic              rx_valid;
   logic [2:0]        rx_status;
   logic [DATA_W-1:0] rx_data;
   logic              cs_ack;
   logic              cs_crs;
   logic [DATA_W-1:0] cs_data;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   cpl_crs_filter #(.OFF_W(OFF_W), .DATA_W(DATA_W)) i_cpl_crs_filter (
      .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_to_cs(cpl_to_cs),
      .cpl_status(cpl_status), .cpl_offset(cpl_offset), .cpl_is_write(cpl_is_write),
      .cpl_data(cpl_data), .crs_vis_en(crs_vis_en), .rx_valid(rx_valid),
      .rx_status(rx_status), .rx_data(rx_data), .cs_ack(cs_ack), .cs_crs(cs_crs),
      .cs_data(cs_data));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         @(negedge clk);
         cpl_valid = 1'b0;
         e.kind = 0; e.status = 3'd0; e.data = 32'h0; e.crs = 1'b0; e.tag = tag;
         sb.push_back(e);
      end
   endtask

   task automatic send(input bit to_cs, input logic [2:0] st, input int off,
                       input bit wr, input logic [31:0] d, input bit vis,
                       input string tag);
      exp_t e;
      bit   hit;
      @(negedge clk);
      cpl_valid    = 1'b1;
      cpl_to_cs    = to_cs;
      cpl_status   = st;
      cpl_offset   = OFF_W'(off);
      cpl_is_write = wr;
      cpl_data     = d;
      crs_vis_en   = vis;
      hit = (st == 3'd2) && vis && !wr && (off == 0);
      e.kind   = to_cs ? 2 : 1;
      e.status = hit ? 3'd0 : st;
      e.data   = hit ? 32'hFFFF_0001 : d;
      e.crs    = (e.status == 3'd2);
      e.tag    = tag;
      sb.push_back(e);
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(rx_valid == (e.kind == 1), e.tag, "rx_valid", 32'(rx_valid), 32'(e.kind == 1));
         chk(cs_ack == (e.kind == 2), e.tag, "cs_ack", 32'(cs_ack), 32'(e.kind == 2));
         if (e.kind == 1) begin
            chk(rx_status == e.status, e.tag, "rx_status", 32'(rx_status), 32'(e.status));
            chk(rx_data == e.data, e.tag, "rx_data", rx_data, e.data);
         end else if (e.kind == 2) begin
            chk(cs_crs == e.crs, e.tag, "cs_crs", 32'(cs_crs), 32'(e.crs));
            chk(cs_data == e.data, e.tag, "cs_data", cs_data, e.data);
         end else begin
            chk(cs_crs == 1'b0, e.tag, "cs_crs idle", 32'(cs_crs), 32'h0);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk(!rx_valid && !cs_ack && !cs_crs, "R1", "strobes in reset",
          {29'h0, rx_valid, cs_ack, cs_crs}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk(!rx_valid && !cs_ack && !cs_crs, "R1", "strobes after reset",
          {29'h0, rx_valid, cs_ack, cs_crs}, 32'h0);

      // R2: non-retry status passes unchanged
      send(0, 3'd0, 0, 0, 32'h1234_ABCD, 1, "R2");
      send(0, 3'd1, 7, 0, 32'h0000_0000, 0, "R2");
      send(0, 3'd4, 0, 1, 32'hDEAD_BEEF, 1, "R2");
      send(1, 3'd0, 0, 0, 32'h8086_1AF4, 1, "R2");
      idle(1, "R8");
      // R3: visibility off keeps retry
      send(0, 3'd2, 0, 0, 32'hCAFE_0002, 0, "R3");
      send(0, 3'd2, 3, 1, 32'h0BAD_F00D, 0, "R3");
      // R4: visibility on, read of offset 0 substituted
      send(0, 3'd2, 0, 0, 32'h5555_AAAA, 1, "R4");
      send(0, 3'd2, 0, 0, 32'hFFFF_FFFF, 1, "R4");
      // R5: visibility on, other requests keep retry
      send(0, 3'd2, 0, 1, 32'h7777_1111, 1, "R5");
      send(0, 3'd2, 1, 0, 32'h2468_ACE0, 1, "R5");
      send(0, 3'd2, (1 << OFF_W) - 1, 0, 32'h1357_9BDF, 1, "R5");
      idle(2, "R8");
      // R6: command/status retry flag with ack
      send(1, 3'd2, 0, 0, 32'hA5A5_5A5A, 0, "R6");
      send(1, 3'd2, 4, 0, 32'h0F0F_F0F0, 1, "R6");
      send(1, 3'd1, 0, 0, 32'h0000_0001, 1, "R6");
      // R7: command/status substitution hides retry
      send(1, 3'd2, 0, 0, 32'h9999_9999, 1, "R7");
      idle(1, "R8");
      // R8: back-to-back and alternating routes
      send(1, 3'd0, 2, 0, 32'h0000_0010, 0, "R8");
      send(1, 3'd0, 2, 0, 32'h0000_0020, 0, "R8");
      send(0, 3'd0, 2, 0, 32'h0000_0030, 0, "R8");
      send(1, 3'd2, 0, 0, 32'h0000_0040, 0, "R8");
      send(0, 3'd2, 0, 0, 32'h0000_0050, 1, "R8");
      idle(3, "R8");
      repeat (2) @(posedge clk);
      #3;
      done = 1'b1;
      summary();
   end
endmodule